// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block is the software-visible register bank of an interrupt distributor shared by several CPUs. Each CPU reaches it over a plain 32-bit word bus: a request carries a valid strobe, a write flag, a 12-bit byte offset, write data and the index of the CPU making the access. A write takes effect at the next rising clock edge. Read data is combinational from the current request and current state. When no read is requested the read data is zero.

The bank holds a global distributor enable and two bitmaps, one for enable and one for pending. Each bitmap has a write-one-to-set view and a write-one-to-clear view. The bank also holds a priority byte and a target byte for every interrupt, and a 2-bit configuration field for every interrupt. Interrupts 0 to 31 are private to each CPU, so their enable and pending bits are banked by the requesting CPU index. Interrupts 0 to 15 are software-generated and can never be disabled.

The target bytes of the private interrupts cannot be written; reading them returns the requester's own CPU bit. Grouping and active state are not implemented, so their banks read as zero. The stored enable, pending and shared-target state is driven out to the routing logic downstream.

Top module: `dist_regfile`

## Requirements
- R1: After reset the distributor enable is 0 and every pending bit is 0. Every priority, target and configuration field reads 0. Every enable bit is 0 except interrupts 0 to 15, which read 1 for every CPU.
- R2: Offset 0x000 stores write-data bit 0 as the distributor enable, driven on `dist_en_o`. A read returns that bit in bit 0, with bits 31:1 zero.
- R3: Offset 0x004 reads ((NUM_CPUS−1)<<5) | (NUM_IRQS/32−1), which is 0x61 at the default parameters. Offset 0x008 reads 0x4B00043B. Writes to either offset change nothing.
- R4: Word w of the enable bitmap covers interrupts 32w to 32w+31, with interrupt 32w+k at bit k. Word w is read at 0x100+4w and at 0x180+4w. Writing 1s at 0x100+4w sets the matching bits; writing 1s at 0x180+4w clears them. Written 0s change nothing.
- R5: Enable bits for interrupts 0 to 15 stay 1 for every CPU, including right after a clear-enable write of all ones.
- R6: The pending bitmap uses the same word and bit layout as the enable bitmap. It is read at 0x200+4w and at 0x280+4w. Writing 1s at 0x200+4w sets bits and writing 1s at 0x280+4w clears them.
- R7: Enable and pending word 0 (interrupts 0 to 31) is a separate copy for each CPU, selected by `req_cpu`. Words 1 and up are one copy shared by all CPUs. `irq_enable_o` and `irq_pending_o` hold CPU c's view at bits [c*NUM_IRQS +: NUM_IRQS].
- R8: The group bank at 0x080 and the active banks at 0x300 and 0x380 read 0, and writes to them change no state.
- R9: Priority word w at 0x400+4w holds interrupts 4w to 4w+3. Interrupt 4w+k sits in bits 8k+7:8k. The word reads back the last value written to it.
- R10: Target word w at 0x800+4w, for w of 8 or more, holds the 8-bit target bytes of interrupts 4w to 4w+3, in the same byte layout as R9. The word reads back the last value written. `spi_target_o` carries interrupt i's byte at bits [(i−32)*8 +: 8].
- R11: Target words 0 to 7 (0x800 to 0x81C) ignore writes. They read as the byte (1 << req_cpu) replicated into all four byte lanes.
- R12: Configuration word w at 0xC00+4w holds interrupts 16w to 16w+15. Interrupt 16w+k sits in bits 2k+1:2k. The word reads back the last value written.
- R13: The following read 0 and have no effect when written: a non-word-aligned offset, an offset outside every bank, and a word of a bank beyond the interrupts that exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_cpu | input | CPU_W | Index of the requesting CPU |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current read request |
| dist_en_o | output | 1 | Global distributor enable |
| irq_enable_o | output | NUM_CPUS*NUM_IRQS | Enable bitmap as seen by each CPU |
| irq_pending_o | output | NUM_CPUS*NUM_IRQS | Pending bitmap as seen by each CPU |
| spi_target_o | output | (NUM_IRQS-32)*8 | Target bytes of the shared interrupts |

## Verification
The bench targets the banking of word 0 by pending a private interrupt from one CPU and then reading it from another. A design with a single shared copy would show the bit to every CPU. It writes all ones to the first clear-enable word. A design missing the forced-on mask would then report interrupts 0 to 15 as disabled. It also writes to the private target words and reads them from different CPUs: a design that stored those writes, or ignored the requester, would return the stored bytes instead of the requester's own one-hot bit. Writes to the group and active banks, to unaligned offsets and to words past the last interrupt are each followed by a readback and a comparison of all outputs. A design that aliased any of these accesses onto a live register would show the change there.

// File: rtl/dist_pkg.sv
package dist_pkg;

    localparam int ADDR_W = 12;
    localparam logic [31:0] IDENT_VALUE = 32'h4B00043B;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CTRL,
        RG_TYPE,
        RG_IDENT,
        RG_ZERO,
        RG_SETEN,
        RG_CLREN,
        RG_SETPD,
        RG_CLRPD,
        RG_PRIO,
        RG_TGT,
        RG_CFG
    } region_e;

    // Map a byte offset to the register region it falls in.
    function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
        region_e r;
        r = RG_NONE;
        if (a[1:0] != 2'b00) begin
            r = RG_NONE;
        end else if (a[11:10] == 2'b01) begin
            r = RG_PRIO;
        end else if (a[11:10] == 2'b10) begin
            r = RG_TGT;
        end else if (a[11:8] == 4'hC) begin
            r = RG_CFG;
        end else if (a[11:10] == 2'b00) begin
            case (a[9:7])
                3'd0: begin
                    if (a[6:2] == 5'd0)      r = RG_CTRL;
                    else if (a[6:2] == 5'd1) r = RG_TYPE;
                    else if (a[6:2] == 5'd2) r = RG_IDENT;
                    else                     r = RG_NONE;
                end
                3'd1:    r = RG_ZERO;
                3'd2:    r = RG_SETEN;
                3'd3:    r = RG_CLREN;
                3'd4:    r = RG_SETPD;
                3'd5:    r = RG_CLRPD;
                default: r = RG_ZERO;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/dist_bitmap_bank.sv
// One bit per interrupt, word 0 banked per CPU, other words shared.
module dist_bitmap_bank #(
    parameter int          NUM_CPUS   = 4,
    parameter int          NUM_IRQS   = 64,
    parameter int          CPU_W      = 2,
    parameter logic [31:0] FORCE_MASK = 32'h0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         set_i,
    input  logic                         clr_i,
    input  logic [4:0]                   word_i,
    input  logic [CPU_W-1:0]             cpu_i,
    input  logic [31:0]                  wdata_i,
    output logic [31:0]                  rdata_o,
    output logic [NUM_CPUS*NUM_IRQS-1:0] vec_o
);

    localparam int WORDS = NUM_IRQS / 32;
    localparam int SHR_W = NUM_IRQS - 32;

    typedef struct packed {
        logic [NUM_CPUS-1:0][31:0] priv;
        logic [SHR_W-1:0]          shr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (word_i == 5'd0) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                if (cpu_i == CPU_W'(c)) begin
                    if (set_i) st_d.priv[c] = st_d.priv[c] | wdata_i;
                    if (clr_i) st_d.priv[c] = st_d.priv[c] & ~wdata_i;
                end
            end
        end else begin
            for (int w = 1; w < WORDS; w++) begin
                if (word_i == 5'(w)) begin
                    if (set_i) st_d.shr[(w-1)*32 +: 32] = st_d.shr[(w-1)*32 +: 32] | wdata_i;
                    if (clr_i) st_d.shr[(w-1)*32 +: 32] = st_d.shr[(w-1)*32 +: 32] & ~wdata_i;
                end
            end
        end
        for (int c = 0; c < NUM_CPUS; c++) begin
            st_d.priv[c] = st_d.priv[c] | FORCE_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                st_q.priv[c] <= FORCE_MASK;
            end
            st_q.shr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (word_i == 5'd0) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                if (cpu_i == CPU_W'(c)) rdata_o = st_q.priv[c];
            end
        end else begin
            for (int w = 1; w < WORDS; w++) begin
                if (word_i == 5'(w)) rdata_o = st_q.shr[(w-1)*32 +: 32];
            end
        end
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_view
        assign vec_o[c*NUM_IRQS +: NUM_IRQS] = {st_q.shr, st_q.priv[c]};
    end

endmodule

// File: rtl/dist_field_bank.sv
// FIELD_W bits per interrupt, packed 32/FIELD_W per word, for interrupts FIRST and up.
module dist_field_bank #(
    parameter int NUM_IRQS = 64,
    parameter int FIELD_W  = 8,
    parameter int FIRST    = 0,
    parameter int IDX_W    = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_i,
    input  logic [IDX_W-1:0]                    word_i,
    input  logic [31:0]                         wdata_i,
    output logic [31:0]                         rdata_o,
    output logic [(NUM_IRQS-FIRST)*FIELD_W-1:0] fields_o
);

    localparam int FPW        = 32 / FIELD_W;
    localparam int STORE_W    = (NUM_IRQS - FIRST) * FIELD_W;
    localparam int NWORDS     = NUM_IRQS / FPW;
    localparam int FIRST_WORD = FIRST / FPW;

    typedef struct packed {
        logic [STORE_W-1:0] f;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            for (int w = FIRST_WORD; w < NWORDS; w++) begin
                if (word_i == IDX_W'(w)) st_d.f[(w-FIRST_WORD)*32 +: 32] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int w = FIRST_WORD; w < NWORDS; w++) begin
            if (word_i == IDX_W'(w)) rdata_o = st_q.f[(w-FIRST_WORD)*32 +: 32];
        end
    end

    assign fields_o = st_q.f;

endmodule

// File: rtl/dist_regfile.sv
module dist_regfile
    import dist_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int NUM_IRQS = 64,
    localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [11:0]                  req_addr,
    input  logic [CPU_W-1:0]             req_cpu,
    input  logic [31:0]                  req_wdata,
    output logic [31:0]                  rd_data,
    output logic                         dist_en_o,
    output logic [NUM_CPUS*NUM_IRQS-1:0] irq_enable_o,
    output logic [NUM_CPUS*NUM_IRQS-1:0] irq_pending_o,
    output logic [(NUM_IRQS-32)*8-1:0]   spi_target_o
);

    localparam logic [31:0] TYPE_VALUE = 32'(((NUM_CPUS - 1) << 5) | (NUM_IRQS / 32 - 1));
    localparam int PRIV_TGT_WORDS = 8;

    region_e region;
    logic    wr_en;
    logic    rd_en;

    assign region = decode_region(req_addr);
    assign wr_en  = req_valid && req_write;
    assign rd_en  = req_valid && !req_write;

    // Global enable, two-process
    typedef struct packed {
        logic en;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && region == RG_CTRL) ctrl_d.en = req_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign dist_en_o = ctrl_q.en;

    // Enable (g=0) and pending (g=1) bitmaps
    logic [31:0]                  bm_rd  [2];
    logic [NUM_CPUS*NUM_IRQS-1:0] bm_vec [2];

    for (genvar g = 0; g < 2; g++) begin : g_bitmap
        localparam region_e SET_RG = (g == 0) ? RG_SETEN : RG_SETPD;
        localparam region_e CLR_RG = (g == 0) ? RG_CLREN : RG_CLRPD;
        localparam logic [31:0] MASK = (g == 0) ? 32'h0000FFFF : 32'h0;

        dist_bitmap_bank #(
            .NUM_CPUS   (NUM_CPUS),
            .NUM_IRQS   (NUM_IRQS),
            .CPU_W      (CPU_W),
            .FORCE_MASK (MASK)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (wr_en && region == SET_RG),
            .clr_i   (wr_en && region == CLR_RG),
            .word_i  (req_addr[6:2]),
            .cpu_i   (req_cpu),
            .wdata_i (req_wdata),
            .rdata_o (bm_rd[g]),
            .vec_o   (bm_vec[g])
        );
    end

    assign irq_enable_o  = bm_vec[0];
    assign irq_pending_o = bm_vec[1];

    // Priority, target and configuration fields
    logic [31:0]            prio_rd, tgt_rd, cfg_rd;
    logic [NUM_IRQS*8-1:0]  prio_fields;
    logic [NUM_IRQS*2-1:0]  cfg_fields;

    dist_field_bank #(
        .NUM_IRQS (NUM_IRQS), .FIELD_W (8), .FIRST (0), .IDX_W (8)
    ) prio_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_en && region == RG_PRIO),
        .word_i   (req_addr[9:2]),
        .wdata_i  (req_wdata),
        .rdata_o  (prio_rd),
        .fields_o (prio_fields)
    );

    dist_field_bank #(
        .NUM_IRQS (NUM_IRQS), .FIELD_W (8), .FIRST (32), .IDX_W (8)
    ) tgt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_en && region == RG_TGT),
        .word_i   (req_addr[9:2]),
        .wdata_i  (req_wdata),
        .rdata_o  (tgt_rd),
        .fields_o (spi_target_o)
    );

    dist_field_bank #(
        .NUM_IRQS (NUM_IRQS), .FIELD_W (2), .FIRST (0), .IDX_W (6)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_en && region == RG_CFG),
        .word_i   (req_addr[7:2]),
        .wdata_i  (req_wdata),
        .rdata_o  (cfg_rd),
        .fields_o (cfg_fields)
    );

    // Stored priority and configuration are software-visible only.
    logic fields_unused;
    assign fields_unused = ^{prio_fields, cfg_fields};

    // Private target words mirror the requester
    logic [7:0]  self_bit;
    logic [31:0] tgt_ro;

    always_comb begin
        self_bit = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (req_cpu == CPU_W'(c)) self_bit[c] = 1'b1;
        end
        tgt_ro = {4{self_bit}};
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (region)
                RG_CTRL:             rd_data = {31'b0, ctrl_q.en};
                RG_TYPE:             rd_data = TYPE_VALUE;
                RG_IDENT:            rd_data = IDENT_VALUE;
                RG_SETEN, RG_CLREN:  rd_data = bm_rd[0];
                RG_SETPD, RG_CLRPD:  rd_data = bm_rd[1];
                RG_PRIO:             rd_data = prio_rd;
                RG_TGT:              rd_data = (req_addr[9:2] < 8'(PRIV_TGT_WORDS)) ? tgt_ro : tgt_rd;
                RG_CFG:              rd_data = cfg_rd;
                default:             rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/dist_regfile_chk.sv
module dist_regfile_chk #(
    parameter int NUM_CPUS = 4,
    parameter int NUM_IRQS = 64,
    localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_write,
    input logic [11:0]                  req_addr,
    input logic [CPU_W-1:0]             req_cpu,
    input logic [31:0]                  req_wdata,
    input logic [31:0]                  rd_data,
    input logic                         dist_en_o,
    input logic [NUM_CPUS*NUM_IRQS-1:0] irq_enable_o,
    input logic [NUM_CPUS*NUM_IRQS-1:0] irq_pending_o,
    input logic [(NUM_IRQS-32)*8-1:0]   spi_target_o
);

    logic sgi_all_on;
    always_comb begin
        sgi_all_on = 1'b1;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (irq_enable_o[c*NUM_IRQS +: 16] != 16'hFFFF) sgi_all_on = 1'b0;
        end
    end

    logic [7:0] own_bit;
    assign own_bit = 8'(1) << req_cpu;

    logic is_raz_bank;
    assign is_raz_bank = (req_addr[1:0] == 2'b00) && (req_addr[11:7] inside {5'd1, 5'd6, 5'd7});

    logic is_ro_word;
    assign is_ro_word = is_raz_bank || req_addr == 12'h004 || req_addr == 12'h008;

    AST_SGI_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        sgi_all_on);  // R5

    AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_addr == 12'h000 |=> dist_en_o == $past(req_wdata[0]));  // R2

    AST_IDENT_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && req_addr == 12'h008 |-> rd_data == 32'h4B00043B);  // R3

    AST_RAZ_BANK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && is_raz_bank |-> rd_data == 32'h0);  // R8

    AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && is_ro_word |=> $stable(dist_en_o) && $stable(irq_enable_o)
            && $stable(irq_pending_o) && $stable(spi_target_o));  // R8

    AST_PRIV_TARGET_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && req_addr[11:5] == 7'b1000000 && req_addr[1:0] == 2'b00
            |-> rd_data == {4{own_bit}});  // R11

    AST_SPI_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_addr == 12'h204
            |=> (irq_pending_o[32 +: 32] & $past(req_wdata)) == $past(req_wdata));  // R6

    AST_SPI_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_addr == 12'h284
            |=> (irq_pending_o[32 +: 32] & $past(req_wdata)) == 32'h0);  // R6

endmodule

bind dist_regfile dist_regfile_chk #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_IRQS (NUM_IRQS)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_cpu       (req_cpu),
    .req_wdata     (req_wdata),
    .rd_data       (rd_data),
    .dist_en_o     (dist_en_o),
    .irq_enable_o  (irq_enable_o),
    .irq_pending_o (irq_pending_o),
    .spi_target_o  (spi_target_o)
);

// File: tb/dist_regfile_tb_top.sv
module dist_regfile_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;
    localparam int NIRQ = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [11:0]       req_addr = '0;
    logic [1:0]        req_cpu = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rd_data;
    logic              dist_en_o;
    logic [NCPU*NIRQ-1:0] irq_enable_o;
    logic [NCPU*NIRQ-1:0] irq_pending_o;
    logic [(NIRQ-32)*8-1:0] spi_target_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dist_regfile #(.NUM_CPUS(NCPU), .NUM_IRQS(NIRQ)) dut_i (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_cpu, .req_wdata,
        .rd_data, .dist_en_o, .irq_enable_o, .irq_pending_o, .spi_target_o
    );

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    // Reference model
    logic        m_ctrl;
    logic [31:0] m_en_priv [NCPU];
    logic [31:0] m_pd_priv [NCPU];
    logic [31:0] m_en_shr, m_pd_shr;
    logic [31:0] m_prio [16];
    logic [31:0] m_tgt  [16];
    logic [31:0] m_cfg  [4];

    task automatic model_reset();
        m_ctrl = 1'b0;
        m_en_shr = '0;
        m_pd_shr = '0;
        for (int c = 0; c < NCPU; c++) begin
            m_en_priv[c] = 32'h0000FFFF;
            m_pd_priv[c] = '0;
        end
        for (int i = 0; i < 16; i++) begin
            m_prio[i] = '0;
            m_tgt[i] = '0;
        end
        for (int i = 0; i < 4; i++) m_cfg[i] = '0;
    endtask

    task automatic model_write(input logic [11:0] a, input int cpu, input logic [31:0] d);
        int w;
        if (a[1:0] != 2'b00) return;
        if (a == 12'h000) m_ctrl = d[0];
        else if (a >= 12'h100 && a < 12'h300) begin
            w = int'(a[6:0]) / 4;
            case (a[9:7])
                3'd2: begin
                    if (w == 0) m_en_priv[cpu] |= d;
                    else if (w == 1) m_en_shr |= d;
                end
                3'd3: begin
                    if (w == 0) m_en_priv[cpu] &= ~d;
                    else if (w == 1) m_en_shr &= ~d;
                    m_en_priv[cpu] |= 32'h0000FFFF;
                end
                3'd4: begin
                    if (w == 0) m_pd_priv[cpu] |= d;
                    else if (w == 1) m_pd_shr |= d;
                end
                default: begin
                    if (w == 0) m_pd_priv[cpu] &= ~d;
                    else if (w == 1) m_pd_shr &= ~d;
                end
            endcase
        end else if (a >= 12'h400 && a < 12'h800) begin
            w = (int'(a) - 'h400) / 4;
            if (w < 16) m_prio[w] = d;
        end else if (a >= 12'h800 && a < 12'hC00) begin
            w = (int'(a) - 'h800) / 4;
            if (w >= 8 && w < 16) m_tgt[w] = d;
        end else if (a >= 12'hC00 && a < 12'hD00) begin
            w = (int'(a) - 'hC00) / 4;
            if (w < 4) m_cfg[w] = d;
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a, input int cpu);
        int w;
        logic [7:0] b;
        if (a[1:0] != 2'b00) return 32'h0;
        if (a == 12'h000) return {31'b0, m_ctrl};
        if (a == 12'h004) return 32'h00000061;
        if (a == 12'h008) return 32'h4B00043B;
        if (a >= 12'h100 && a < 12'h200) begin
            w = int'(a[6:0]) / 4;
            return (w == 0) ? m_en_priv[cpu] : (w == 1) ? m_en_shr : 32'h0;
        end
        if (a >= 12'h200 && a < 12'h300) begin
            w = int'(a[6:0]) / 4;
            return (w == 0) ? m_pd_priv[cpu] : (w == 1) ? m_pd_shr : 32'h0;
        end
        if (a >= 12'h400 && a < 12'h800) begin
            w = (int'(a) - 'h400) / 4;
            return (w < 16) ? m_prio[w] : 32'h0;
        end
        if (a >= 12'h800 && a < 12'hC00) begin
            w = (int'(a) - 'h800) / 4;
            b = 8'(1) << cpu;
            if (w < 8) return {b, b, b, b};
            return (w < 16) ? m_tgt[w] : 32'h0;
        end
        if (a >= 12'hC00 && a < 12'hD00) begin
            w = (int'(a) - 'hC00) / 4;
            return (w < 4) ? m_cfg[w] : 32'h0;
        end
        return 32'h0;
    endfunction

    function automatic string req_of(input logic [11:0] a);
        if (a[1:0] != 2'b00) return "R13";
        if (a == 12'h000) return "R2";
        if (a == 12'h004 || a == 12'h008) return "R3";
        if (a[11:7] == 5'd1 || a[11:7] == 5'd6 || a[11:7] == 5'd7) return "R8";
        if (a >= 12'h100 && a < 12'h200) return "R4";
        if (a >= 12'h200 && a < 12'h300) return "R6";
        if (a >= 12'h400 && a < 12'h800) return "R9";
        if (a >= 12'h800 && a < 12'h820) return "R11";
        if (a >= 12'h820 && a < 12'hC00) return "R10";
        if (a >= 12'hC00 && a < 12'hD00) return "R12";
        return "R13";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input int cpu, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = a;
        req_cpu   = 2'(cpu);
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        model_write(a, cpu, d);
    endtask

    task automatic do_read(input logic [11:0] a, input int cpu, input string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = a;
        req_cpu   = 2'(cpu);
        req_wdata = $urandom;
        #1;
        chk(req, rd_data, exp_read(a, cpu));
        req_valid = 1'b0;
    endtask

    task automatic chk_outputs(input string req);
        @(negedge clk);
        #1;
        chk(req, {31'b0, dist_en_o}, {31'b0, m_ctrl});
        for (int c = 0; c < NCPU; c++) begin
            chk(req, irq_enable_o[c*NIRQ +: 32],       m_en_priv[c]);
            chk(req, irq_enable_o[c*NIRQ + 32 +: 32],  m_en_shr);
            chk(req, irq_pending_o[c*NIRQ +: 32],      m_pd_priv[c]);
            chk(req, irq_pending_o[c*NIRQ + 32 +: 32], m_pd_shr);
        end
        for (int w = 8; w < 16; w++) begin
            chk(req, spi_target_o[(w-8)*32 +: 32], m_tgt[w]);
        end
    endtask

    function automatic logic [11:0] rand_addr();
        int u;
        u = int'($urandom % 32'd20);
        case ($urandom % 32'd12)
            0:  return 12'h000;
            1:  return (u % 2 == 0) ? 12'h004 : 12'h008;
            2:  return 12'h080 + 12'(4 * (u % 3));
            3:  return 12'h100 + 12'(4 * (u % 3));
            4:  return 12'h180 + 12'(4 * (u % 3));
            5:  return 12'h200 + 12'(4 * (u % 3));
            6:  return 12'h280 + 12'(4 * (u % 3));
            7:  return ((u % 2) == 0 ? 12'h300 : 12'h380) + 12'(4 * (u % 2));
            8:  return 12'h400 + 12'(4 * (u % 18));
            9:  return 12'h800 + 12'(4 * (u % 18));
            10: return 12'hC00 + 12'(4 * (u % 6));
            default: begin
                case (u % 4)
                    0: return 12'hF00;
                    1: return 12'hD00;
                    2: return 12'h00C;
                    default: return 12'h102;
                endcase
            end
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [11:0] a;
        int          cpu;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_outputs("R1");
        do_read(12'h000, 0, "R1");
        do_read(12'h40C, 1, "R1");
        do_read(12'h824, 2, "R1");
        do_read(12'hC04, 3, "R1");
        do_read(12'h100, 3, "R1");

        // R2 control
        do_write(12'h000, 0, 32'hFFFF_FFFF);
        do_read(12'h000, 1, "R2");
        chk_outputs("R2");
        do_write(12'h000, 2, 32'hFFFF_FFFE);
        do_read(12'h000, 0, "R2");

        // R3 read-only identity words
        do_read(12'h004, 0, "R3");
        do_read(12'h008, 3, "R3");
        do_write(12'h004, 0, 32'h1234_5678);
        do_write(12'h008, 1, 32'h0);
        do_read(12'h004, 2, "R3");
        do_read(12'h008, 0, "R3");
        chk_outputs("R3");

        // R4 enable set and clear views
        do_write(12'h104, 0, 32'hA5A5_A5A5);
        do_read(12'h104, 1, "R4");
        do_read(12'h184, 2, "R4");
        do_write(12'h184, 3, 32'h0000_FFFF);
        do_read(12'h104, 0, "R4");
        do_write(12'h100, 1, 32'h8001_0000);
        do_read(12'h180, 1, "R4");
        chk_outputs("R4");

        // R5 software-generated interrupts stay enabled
        do_write(12'h180, 1, 32'hFFFF_FFFF);
        do_read(12'h100, 1, "R5");
        chk_outputs("R5");

        // R6 pending
        do_write(12'h204, 0, 32'h0F0F_0003);
        do_read(12'h204, 3, "R6");
        do_write(12'h284, 2, 32'h0000_0001);
        do_read(12'h284, 0, "R6");
        chk_outputs("R6");

        // R7 banking of word 0
        do_write(12'h200, 2, 32'h0001_0000);
        do_read(12'h200, 2, "R7");
        do_read(12'h200, 0, "R7");
        do_write(12'h100, 3, 32'h4000_0000);
        do_read(12'h100, 1, "R7");
        chk_outputs("R7");

        // R8 group and active banks
        do_write(12'h080, 0, 32'hFFFF_FFFF);
        do_write(12'h300, 1, 32'hFFFF_FFFF);
        do_write(12'h384, 2, 32'hFFFF_FFFF);
        do_read(12'h080, 0, "R8");
        do_read(12'h300, 1, "R8");
        do_read(12'h384, 2, "R8");
        chk_outputs("R8");

        // R9 priority
        do_write(12'h408, 0, 32'h1122_3344);
        do_read(12'h408, 3, "R9");
        do_write(12'h43C, 1, 32'hDEAD_BEEF);
        do_read(12'h43C, 0, "R9");

        // R10 shared targets
        do_write(12'h820, 0, 32'h0F03_0201);
        do_read(12'h820, 1, "R10");
        do_write(12'h83C, 2, 32'h0804_0201);
        chk_outputs("R10");

        // R11 private targets mirror requester
        do_read(12'h800, 3, "R11");
        do_write(12'h804, 0, 32'hFFFF_FFFF);
        do_read(12'h804, 1, "R11");
        do_read(12'h81C, 0, "R11");

        // R12 configuration
        do_write(12'hC04, 0, 32'hAAAA_5555);
        do_read(12'hC04, 2, "R12");
        do_write(12'hC0C, 3, 32'h1234_ABCD);
        do_read(12'hC0C, 1, "R12");

        // R13 unmapped, unaligned and out-of-range words
        do_write(12'hF00, 0, 32'hFFFF_FFFF);
        do_write(12'hD00, 1, 32'hFFFF_FFFF);
        do_write(12'h108, 2, 32'hFFFF_FFFF);
        do_write(12'h201, 0, 32'hFFFF_FFFF);
        do_write(12'h440, 0, 32'hFFFF_FFFF);
        do_read(12'hF00, 0, "R13");
        do_read(12'h108, 2, "R13");
        do_read(12'h201, 0, "R13");
        do_read(12'h440, 0, "R13");
        do_read(12'h200, 0, "R13");
        chk_outputs("R13");

        // Constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            a = rand_addr();
            cpu = int'($urandom % 32'd4);
            d = $urandom;
            if ($urandom % 2 == 0) do_write(a, cpu, d);
            else                   do_read(a, cpu, req_of(a));
            if (i % 100 == 99) chk_outputs("R7");
        end
        chk_outputs("R4");

        finish_run();
    end

endmodule